// File: doc/BRIEF.md
# Error Record Queue with Read-and-Pop Responder

This block collects error records produced elsewhere on the chip and hands them to a host one at a time. A record pairs a 32-bit location word with a 32-bit data word. Records enter through a push port qualified by a valid strobe and are kept in first-in, first-out order. A level output tells the rest of the system whether any record is waiting.

A host reads the queue by presenting a command code on a small command port. When the code matches the read code, the block returns a word stream over a valid/ready response channel. The first word is always the number of records waiting. If that number is nonzero, the location and data words of the oldest record follow, and that record leaves the queue. Any other command code is accepted and then discarded. A sticky flag records that a push was lost because the queue had no free slot.

Top module: `errq_reader`

## Requirements
- R1: After reset, err_flag and overflow are low, rsp_valid is low and cmd_ready is high.
- R2: err_flag is high exactly when one or more records are queued. It follows each push or pop one cycle after the clock edge at which that push or pop took effect.
- R3: A read command is code 0x3C, taken when cmd_valid and cmd_ready are both high. With an empty queue it returns exactly one word: the value 0, with rsp_last high.
- R4: With a non-empty queue, a read returns three words in this order: count, location, data. rsp_last is high only on the third word.
- R5: The count word is a zero-extended 32-bit value. It equals the number of records queued just before the read removed one.
- R6: Each read removes exactly one record, and it is always the oldest one. Records therefore come out in the order they were pushed.
- R7: A push that arrives in the same cycle as a read command is accepted. This holds even when the queue is full, because the read frees a slot.
- R8: A push into a full queue with no read in the same cycle is dropped. It sets overflow, which then stays high until reset.
- R9: While rsp_valid is high and rsp_ready is low, rsp_data and rsp_last hold steady. Exactly one word moves per cycle in which both are high. cmd_ready stays low until the last word has been taken.
- R10: A command whose code is not 0x3C is accepted and has no effect. No response is produced and the queue contents are unchanged.
- R11: The first response word is valid in the cycle that follows the clock edge at which the read command was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | A new error record is presented |
| push_loc | input | 32 | Location word of the pushed record |
| push_data | input | 32 | Data word of the pushed record |
| cmd_valid | input | 1 | Command code is presented |
| cmd_code | input | CMD_W (8) | Command code; 0x3C means read |
| cmd_ready | output | 1 | Block can take a command (no response in flight) |
| rsp_valid | output | 1 | Response word available |
| rsp_data | output | 32 | Response word |
| rsp_last | output | 1 | Current word is the final one of the response |
| rsp_ready | input | 1 | Host takes the response word |
| err_flag | output | 1 | At least one record is queued |
| overflow | output | 1 | Sticky: a push was dropped on a full queue |

## Verification
The bench builds the block with DEPTH set to 4 instead of the default 16. With so few slots, a random mix of pushes and reads fills the queue often. That brings dropped pushes, the sticky overflow flag, and a push arriving together with a read on a full queue well within reach, alongside the empty single-word case. Random back-pressure on rsp_ready exercises the hold rule on every response word.

// File: rtl/errq_pkg.sv
package errq_pkg;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic [WORD_W-1:0] loc;
    logic [WORD_W-1:0] data;
  } err_rec_t;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_COUNT,
    RS_LOC,
    RS_DATA
  } rsp_state_e;
endpackage

// File: rtl/errq_fifo.sv
module errq_fifo
  import errq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  err_rec_t         wr_rec,
  input  logic             rd_en,
  output err_rec_t         rd_rec,
  output logic [CNT_W-1:0] occ,
  output logic             ovf
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  err_rec_t         store [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] occ_q, occ_d;
  logic             ovf_q, ovf_d;
  logic             full, wr_take, rd_take;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  // next-state logic
  always_comb begin
    full     = (occ_q == FULL_CNT);
    rd_take  = rd_en && (occ_q != '0);
    // a pop in the same cycle frees the slot a full queue needs
    wr_take  = wr_en && (!full || rd_take);
    wr_ptr_d = wr_take ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = rd_take ? bump(rd_ptr_q) : rd_ptr_q;
    case ({wr_take, rd_take})
      2'b10:   occ_d = occ_q + CNT_W'(1);
      2'b01:   occ_d = occ_q - CNT_W'(1);
      default: occ_d = occ_q;
    endcase
    ovf_d = ovf_q || (wr_en && !wr_take);
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_d;
      ovf_q    <= ovf_d;
    end
  end

  // record storage, write-enabled, not reset
  always_ff @(posedge clk) begin
    if (wr_take) begin
      store[wr_ptr_q] <= wr_rec;
    end
  end

  assign rd_rec = store[rd_ptr_q];
  assign occ    = occ_q;
  assign ovf    = ovf_q;
endmodule

// File: rtl/errq_resp.sv
module errq_resp
  import errq_pkg::*;
#(
  parameter int unsigned           CMD_W    = 8,
  parameter logic [CMD_W-1:0]      CMD_CODE = 8'h3C,
  parameter int unsigned           CNT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  output logic              cmd_ready,
  input  logic [CNT_W-1:0]  occ,
  input  err_rec_t          head,
  output logic              pop,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_last,
  input  logic              rsp_ready
);
  rsp_state_e        state_q, state_d;
  logic [WORD_W-1:0] cnt_q, cnt_d;
  err_rec_t          rec_q, rec_d;
  logic              load_en;
  logic              cmd_fire, read_fire;

  // next-state logic
  always_comb begin
    cmd_ready = (state_q == RS_IDLE);
    cmd_fire  = cmd_valid && cmd_ready;
    read_fire = cmd_fire && (cmd_code == CMD_CODE);
    pop       = read_fire && (occ != '0);
    load_en   = read_fire;
    cnt_d     = {{(WORD_W-CNT_W){1'b0}}, occ};
    rec_d     = head;
    state_d   = state_q;
    case (state_q)
      RS_IDLE:  if (read_fire) state_d = RS_COUNT;
      RS_COUNT: if (rsp_ready) state_d = (cnt_q == '0) ? RS_IDLE : RS_LOC;
      RS_LOC:   if (rsp_ready) state_d = RS_DATA;
      RS_DATA:  if (rsp_ready) state_d = RS_IDLE;
      default:  state_d = RS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
      rec_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_en) begin
        cnt_q <= cnt_d;
        rec_q <= rec_d;
      end
    end
  end

  // output mux
  always_comb begin
    rsp_valid = (state_q != RS_IDLE);
    case (state_q)
      RS_COUNT: rsp_data = cnt_q;
      RS_LOC:   rsp_data = rec_q.loc;
      RS_DATA:  rsp_data = rec_q.data;
      default:  rsp_data = '0;
    endcase
    rsp_last = ((state_q == RS_COUNT) && (cnt_q == '0)) || (state_q == RS_DATA);
  end
endmodule

// File: rtl/errq_reader.sv
module errq_reader
  import errq_pkg::*;
#(
  parameter int unsigned      DEPTH    = 16,
  parameter int unsigned      CMD_W    = 8,
  parameter logic [CMD_W-1:0] CMD_CODE = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [WORD_W-1:0] push_loc,
  input  logic [WORD_W-1:0] push_data,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  output logic              cmd_ready,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_last,
  input  logic              rsp_ready,
  output logic              err_flag,
  output logic              overflow
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  err_rec_t         push_rec;
  err_rec_t         head_rec;
  logic [CNT_W-1:0] occ;
  logic             pop;

  assign push_rec = '{loc: push_loc, data: push_data};

  errq_fifo #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (push_valid),
    .wr_rec (push_rec),
    .rd_en  (pop),
    .rd_rec (head_rec),
    .occ    (occ),
    .ovf    (overflow)
  );

  errq_resp #(
    .CMD_W    (CMD_W),
    .CMD_CODE (CMD_CODE),
    .CNT_W    (CNT_W)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_ready (cmd_ready),
    .occ       (occ),
    .head      (head_rec),
    .pop       (pop),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last),
    .rsp_ready (rsp_ready)
  );

  assign err_flag = (occ != '0);
endmodule

// File: rtl/errq_checker.sv
module errq_checker #(
  parameter int unsigned      CMD_W    = 8,
  parameter logic [CMD_W-1:0] CMD_CODE = 8'h3C
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_code,
  input logic             cmd_ready,
  input logic             rsp_valid,
  input logic [31:0]      rsp_data,
  input logic             rsp_last,
  input logic             rsp_ready,
  input logic             err_flag,
  input logic             overflow
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_last)); // R9

  AST_BUSY_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready); // R9

  AST_EMPTY_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_code == CMD_CODE) && !err_flag
      |=> rsp_valid && rsp_last && (rsp_data == 32'd0)); // R3

  AST_FIRST_OF_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_code == CMD_CODE) && err_flag
      |=> rsp_valid && !rsp_last && (rsp_data != 32'd0)); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !err_flag |=> err_flag); // R2

  AST_OTHER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_code != CMD_CODE) |=> !rsp_valid); // R10
endmodule

bind errq_reader errq_checker #(
  .CMD_W    (CMD_W),
  .CMD_CODE (CMD_CODE)
) u_errq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .cmd_ready  (cmd_ready),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .rsp_last   (rsp_last),
  .rsp_ready  (rsp_ready),
  .err_flag   (err_flag),
  .overflow   (overflow)
);

// File: tb/tb_errq_reader.sv
module tb_errq_reader;
  localparam int DEPTH = 4;
  localparam logic [7:0] RD_CODE = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_valid;
  logic [31:0] push_loc, push_data;
  logic        cmd_valid;
  logic [7:0]  cmd_code;
  logic        cmd_ready;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_last;
  logic        rsp_ready;
  logic        err_flag;
  logic        overflow;

  int total = 0;
  int bad   = 0;
  logic [63:0] model_q[$];
  bit ovf_exp = 1'b0;

  always #2 clk = ~clk;

  errq_reader #(.DEPTH(DEPTH), .CMD_W(8), .CMD_CODE(RD_CODE)) dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_loc(push_loc),
    .push_data(push_data), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .rsp_ready(rsp_ready), .err_flag(err_flag),
    .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_push(input logic [31:0] l, input logic [31:0] d);
    if (model_q.size() < DEPTH) model_q.push_back({l, d});
    else ovf_exp = 1'b1;
  endfunction

  task automatic check_flags();
    chk(err_flag == (model_q.size() != 0), "R2 err_flag", 32'(err_flag), 32'(model_q.size() != 0));
    chk(overflow == ovf_exp, "R8 overflow", 32'(overflow), 32'(ovf_exp));
  endtask

  task automatic push_only(input logic [31:0] l, input logic [31:0] d);
    push_valid = 1'b1; push_loc = l; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
    model_push(l, d);
    check_flags();
  endtask

  task automatic issue_cmd(input logic [7:0] code, input bit with_push,
                           input logic [31:0] l, input logic [31:0] d, input int stall_max);
    logic [31:0] exp_w[3];
    int nw;
    logic [63:0] rec;
    chk(cmd_ready == 1'b1, "R9 cmd_ready idle", 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1; cmd_code = code;
    if (with_push) begin
      push_valid = 1'b1; push_loc = l; push_data = d;
    end
    @(negedge clk);
    cmd_valid = 1'b0; push_valid = 1'b0;
    if (code != RD_CODE) begin
      if (with_push) model_push(l, d);
      chk(rsp_valid == 1'b0, "R10 no response", 32'(rsp_valid), 32'd0);
      check_flags();
      return;
    end
    exp_w[0] = 32'(model_q.size());
    nw = 1;
    if (model_q.size() != 0) begin
      rec = model_q.pop_front();
      exp_w[1] = rec[63:32];
      exp_w[2] = rec[31:0];
      nw = 3;
    end
    if (with_push) model_push(l, d);
    chk(rsp_valid == 1'b1, "R11 first word valid", 32'(rsp_valid), 32'd1);
    for (int i = 0; i < nw; i++) begin
      int stalls = $urandom_range(0, stall_max);
      for (int s = 0; s < stalls; s++) begin
        @(negedge clk);
        chk(rsp_valid && rsp_data == exp_w[i], "R9 hold under stall", rsp_data, exp_w[i]);
      end
      rsp_ready = 1'b1;
      if (i == 0) chk(rsp_data == exp_w[0], "R5 count word", rsp_data, exp_w[0]);
      else        chk(rsp_data == exp_w[i], "R6 oldest record word", rsp_data, exp_w[i]);
      if (nw == 1) chk(rsp_last == 1'b1, "R3 single last", 32'(rsp_last), 32'd1);
      else chk(rsp_last == (i == 2), "R4 last on third", 32'(rsp_last), 32'(i == 2));
      @(negedge clk);
      rsp_ready = 1'b0;
    end
    chk(rsp_valid == 1'b0, "R9 response ended", 32'(rsp_valid), 32'd0);
    check_flags();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_q.delete();
    ovf_exp = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    push_valid = 0; push_loc = 0; push_data = 0;
    cmd_valid = 0; cmd_code = 0; rsp_ready = 0;
    do_reset();
    // R1 reset state
    chk(!err_flag && !overflow, "R1 flags after reset", {30'd0, err_flag, overflow}, 32'd0);
    chk(!rsp_valid && cmd_ready, "R1 handshake after reset", {30'd0, rsp_valid, cmd_ready}, 32'd1);

    // R3 read on empty
    issue_cmd(RD_CODE, 1'b0, 0, 0, 0);
    // R4/R6 ordered reads
    push_only(32'hA000_0001, 32'hD000_0001);
    push_only(32'hA000_0002, 32'hD000_0002);
    issue_cmd(RD_CODE, 1'b0, 0, 0, 2);
    // R10 other code ignored
    issue_cmd(8'h10, 1'b0, 0, 0, 0);
    issue_cmd(RD_CODE, 1'b0, 0, 0, 0);
    chk(err_flag == 1'b0, "R2 flag low after drain", 32'(err_flag), 32'd0);
    // R7 fill, then read with push on a full queue
    for (int k = 0; k < DEPTH; k++) push_only(32'hB000_0000 + k, 32'hC000_0000 + k);
    issue_cmd(RD_CODE, 1'b1, 32'hB000_00FF, 32'hC000_00FF, 1);
    chk(overflow == 1'b0, "R7 push with pop on full not dropped", 32'(overflow), 32'd0);
    for (int k = 0; k < DEPTH; k++) issue_cmd(RD_CODE, 1'b0, 0, 0, 0);
    // R8 overflow
    for (int k = 0; k < DEPTH + 1; k++) push_only(32'hE000_0000 + k, 32'hF000_0000 + k);
    chk(overflow == 1'b1, "R8 overflow set", 32'(overflow), 32'd1);
    issue_cmd(RD_CODE, 1'b0, 0, 0, 0);
    chk(overflow == 1'b1, "R8 overflow sticky", 32'(overflow), 32'd1);
    do_reset();
    chk(overflow == 1'b0, "R8 overflow cleared by reset", 32'(overflow), 32'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      logic [31:0] l = $urandom;
      logic [31:0] d = $urandom;
      if (op < 4)       push_only(l, d);
      else if (op < 7)  issue_cmd(RD_CODE, 1'b0, 0, 0, 3);
      else if (op < 9)  issue_cmd(RD_CODE, 1'b1, l, d, 3);
      else              issue_cmd(8'($urandom_range(0, 59)), $urandom_range(0, 1) == 1, l, d, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule